// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This unit performs integer division and remainder for a 64-bit processor pipeline. An operand pair and a 3-bit operation code are offered on a valid/ready handshake. For each accepted request, the unit returns exactly one result, marked by a single-cycle done pulse. Signed, unsigned and 32-bit word forms are supported.

Two operand pairs are handled at issue and never enter the iterative path: a zero divisor, and a most-negative dividend paired with a minus-one divisor. These return fixed results on the following cycle and raise no exception. All other operations follow the same sequence:

- Magnitudes are formed from the operands.
- A restoring shift-subtract engine produces one quotient bit per cycle.
- A final cycle restores the signs and applies word-form extension.

Top module: `div_unit`

## Requirements
- R1: Unsigned operations return floor(a/b) as the quotient and a mod b as the remainder, both over the full 64 bits.
- R2: Signed operations truncate toward zero. The quotient is negative when the operand signs differ. A non-zero remainder has the sign of the dividend.
- R3: A divide with a zero divisor returns all ones, whether signed or unsigned and in either width.
- R4: A remainder with a zero divisor returns the dividend. In the word forms this is the low 32 bits of the dividend, sign-extended to 64 bits.
- R5: Signed overflow returns the dividend as the quotient and zero as the remainder. Overflow means the dividend is the most negative value of the operating width and the divisor is minus one.
- R6: Signed word forms use the sign-extended low 32 bits of each operand and sign-extend the 32-bit result. The upper 32 bits of the inputs have no effect.
- R7: Unsigned word forms use the zero-extended low 32 bits of each operand, and still sign-extend bit 31 of the result.
- R8: in_op is decoded as follows:
  - bit 0 set selects unsigned.
  - bit 1 set selects remainder; bit 1 clear selects quotient.
  - bit 2 set selects the 32-bit word form.
- R9: Latency is counted in rising edges, with the accepting edge as the first.
  - For a zero divisor or signed overflow, out_done rises at the accepting edge and in_ready stays high.
  - Otherwise in_ready falls after the accepting edge, and out_done with in_ready rises at the 66th edge: 64 engine steps plus one fix-up.
- R10: After reset, out_done is low and in_ready is high.
- R11: in_valid while in_ready is low is not accepted. It does not change the result in progress and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 3 | {word, remainder, unsigned} |
| in_a | input | 64 | Dividend |
| in_b | input | 64 | Divisor |
| out_done | output | 1 | One-cycle result strobe |
| out_result | output | 64 | Quotient or remainder |

## Verification
Directed operand pairs cover all four sign combinations, so a mistake in quotient negation or remainder sign placement appears on at least one of them. Large unsigned dividends with the top bit set separate true unsigned division from signed handling. Word-form operands carry non-zero upper halves, which shows that those bits are ignored and that bit 31 of the result is extended. Zero divisors and the overflow pair are issued in every width and mode, and their one-edge latency is compared with the 66-edge latency of the iterative path.

// File: rtl/div_pkg.sv
package div_pkg;
    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;
    localparam int STEPS = XLEN;
    localparam int CNTW = $clog2(STEPS);

    typedef struct packed {
        logic word;
        logic rem;
        logic uns;
    } div_op_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} div_state_t;

    typedef struct packed {
        logic [XLEN-1:0] mag_a;
        logic [XLEN-1:0] mag_b;
        logic            neg_q;
        logic            neg_r;
        logic            dz;
        logic            ovf;
        logic [XLEN-1:0] spec_val;
    } div_prep_t;

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] ext_half(input logic [HALF-1:0] v, input logic uns);
        return uns ? {{HALF{1'b0}}, v} : sext_half(v);
    endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
#(
    parameter int W = XLEN
) (
    input  div_op_t         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output div_prep_t       prep
);
    logic [W-1:0] a_x, b_x, min_x, spec_raw;
    logic sign_a, sign_b;

    always_comb begin
        a_x    = op.word ? ext_half(a[HALF-1:0], op.uns) : a;
        b_x    = op.word ? ext_half(b[HALF-1:0], op.uns) : b;
        sign_a = !op.uns && a_x[W-1];
        sign_b = !op.uns && b_x[W-1];
        min_x  = op.word ? sext_half({1'b1, {(HALF-1){1'b0}}}) : {1'b1, {(W-1){1'b0}}};

        prep.mag_a = sign_a ? (~a_x + 1'b1) : a_x;
        prep.mag_b = sign_b ? (~b_x + 1'b1) : b_x;
        prep.neg_q = sign_a ^ sign_b;
        prep.neg_r = sign_a;
        prep.dz    = (b_x == '0);
        prep.ovf   = !op.uns && (a_x == min_x) && (b_x == '1);

        if (prep.dz) spec_raw = op.rem ? a_x : '1;
        else         spec_raw = op.rem ? '0 : a_x;
        prep.spec_val = op.word ? sext_half(spec_raw[HALF-1:0]) : spec_raw;
    end
endmodule

// File: rtl/div_core.sv
module div_core
    import div_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = STEPS,
    localparam int CW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         last,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0]  dv_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    always_comb begin
        trial = {rem, quo[W-1]};
        diff  = trial - {1'b0, dv_q};
        fits  = (trial >= {1'b0, dv_q});
        last  = busy && (cnt_q == CW'(N - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            quo   <= '0;
            rem   <= '0;
            dv_q  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            quo   <= dividend;
            rem   <= '0;
            dv_q  <= divisor;
        end else if (busy) begin
            rem   <= fits ? diff[W-1:0] : trial[W-1:0];
            quo   <= {quo[W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
            if (last) busy <= 1'b0;
        end
    end

    // R1: restoring invariant, partial remainder stays below divisor
    p_rem_below_r1: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem < dv_q));
    // R9: engine is never restarted mid-run
    p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/div_fix.sv
module div_fix
    import div_pkg::*;
#(
    parameter int W = XLEN
) (
    input  div_op_t      op,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    output logic [W-1:0] result
);
    logic [W-1:0] q_s, r_s, pick;
    always_comb begin
        q_s    = neg_q ? (~quo + 1'b1) : quo;
        r_s    = neg_r ? (~rem + 1'b1) : rem;
        pick   = op.rem ? r_s : q_s;
        result = op.word ? sext_half(pick[HALF-1:0]) : pick;
    end
endmodule

// File: rtl/div_unit.sv
module div_unit
    import div_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [2:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_done,
    output logic [W-1:0] out_result
);
    div_state_t state;
    div_op_t    op_in, op_q;
    div_prep_t  prep;
    logic       neg_q_q, neg_r_q, fire, special;
    logic       core_busy, core_last;
    logic [W-1:0] core_quo, core_rem, fix_res;

    assign op_in    = div_op_t'(in_op);
    assign in_ready = (state == ST_IDLE);
    assign fire     = in_valid && in_ready;
    assign special  = prep.dz || prep.ovf;

    div_prep #(.W(W)) u_prep (.op(op_in), .a(in_a), .b(in_b), .prep(prep));

    div_core #(.W(W), .N(STEPS)) u_core (
        .clk(clk), .rst(rst), .start(fire && !special),
        .dividend(prep.mag_a), .divisor(prep.mag_b),
        .busy(core_busy), .last(core_last), .quo(core_quo), .rem(core_rem)
    );

    div_fix #(.W(W)) u_fix (
        .op(op_q), .neg_q(neg_q_q), .neg_r(neg_r_q),
        .quo(core_quo), .rem(core_rem), .result(fix_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            op_q       <= '0;
            neg_q_q    <= 1'b0;
            neg_r_q    <= 1'b0;
            out_done   <= 1'b0;
            out_result <= '0;
        end else begin
            out_done <= 1'b0;
            case (state)
                ST_IDLE: if (fire) begin
                    if (special) begin
                        out_result <= prep.spec_val;
                        out_done   <= 1'b1;
                    end else begin
                        op_q    <= op_in;
                        neg_q_q <= prep.neg_q;
                        neg_r_q <= prep.neg_r;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: if (core_last) state <= ST_FIX;
                ST_FIX: begin
                    out_result <= fix_res;
                    out_done   <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: iterative request drops ready on the next cycle
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && !special) |=> (!in_ready && core_busy));
    // R9: special cases finish at once and keep ready high
    p_special_fast_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && special) |=> (out_done && in_ready));
    // R3: divide by zero yields all ones
    p_dz_quot_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && prep.dz && !in_op[1]) |=> (out_result == '1));
    // R4: remainder by zero yields the dividend
    p_dz_rem_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && prep.dz && in_op[1]) |=>
        (out_result == ($past(in_op[2]) ? sext_half($past(in_a[HALF-1:0])) : $past(in_a))));
    // R5: overflow remainder is zero
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && prep.ovf && in_op[1]) |=> (out_result == '0));
    // R11: no done pulse while the engine still runs
    p_no_early_done_r11: assert property (@(posedge clk) disable iff (rst)
        core_busy |-> !out_done);
endmodule

// File: tb/tb_div_unit.sv
module tb_div_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, in_ready, out_done;
    logic [2:0] in_op = '0;
    logic [W-1:0] in_a = '0, in_b = '0, out_result;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    div_unit dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_done(out_done), .out_result(out_result));

    // op codes: bit2 word, bit1 remainder, bit0 unsigned (R8)
    localparam logic [2:0] DIV = 3'b000, DIVU = 3'b001, REM = 3'b010, REMU = 3'b011;
    localparam logic [2:0] DIVW = 3'b100, DIVUW = 3'b101, REMW = 3'b110, REMUW = 3'b111;

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [31:0] a32, b32, r32;
        logic [63:0] r;
        a32 = a[31:0]; b32 = b[31:0];
        if (op[2]) begin
            if (b32 == 0) r32 = op[1] ? a32 : 32'hFFFF_FFFF;
            else if (!op[0] && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) r32 = op[1] ? 32'h0 : a32;
            else if (op[0]) r32 = op[1] ? a32 % b32 : a32 / b32;
            else r32 = op[1] ? 32'($signed(a32) % $signed(b32)) : 32'($signed(a32) / $signed(b32));
            return sx32(r32);
        end
        if (b == 0) r = op[1] ? a : '1;
        else if (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1) r = op[1] ? 64'h0 : a;
        else if (op[0]) r = op[1] ? a % b : a / b;
        else r = op[1] ? 64'($signed(a) % $signed(b)) : 64'($signed(a) / $signed(b));
        return r;
    endfunction

    function automatic bit is_special(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        if (op[2]) return (b[31:0] == 0) || (!op[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF);
        return (b == 0) || (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one op; optionally hammer in_valid while busy (R11).
    task automatic run_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                          input string req, input bit hammer);
        logic [63:0] exp;
        int lat, exp_lat;
        exp = model(op, a, b);
        exp_lat = is_special(op, a, b) ? 1 : 66;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        if (hammer) begin
            in_op = DIVU; in_a = 64'd999; in_b = 64'd3;
        end else in_valid = 1'b0;
        lat = 1;
        if (exp_lat > 1) check(!in_ready, {req, " R9 ready low"}, 64'(in_ready), 64'd0);
        while (!out_done && lat < 200) begin
            if (hammer && lat == 10) in_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
        in_valid = 1'b0;
        check(out_result == exp, req, out_result, exp);
        check(lat == exp_lat, {req, " R9 latency"}, 64'(lat), 64'(exp_lat));
        check(in_ready, {req, " R9 ready back"}, 64'(in_ready), 64'd1);
    endtask

    task automatic t_reset;
        check(!out_done, "R10 done", 64'(out_done), 64'd0);
        check(in_ready, "R10 ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_unsigned;
        run_op(DIVU, 64'd100, 64'd7, "R1 divu", 0);
        run_op(REMU, 64'd100, 64'd7, "R1 remu", 0);
        run_op(DIVU, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R1 divu big", 0);
        run_op(REMU, 64'h8000_0000_0000_0005, 64'h10, "R1 remu top bit", 0);
        run_op(DIVU, 64'd5, 64'd9, "R1 divu small", 0);
    endtask

    task automatic t_signed;
        run_op(DIV, -64'sd7, 64'sd2, "R2 div -/+", 0);
        run_op(REM, -64'sd7, 64'sd2, "R2 rem -/+", 0);
        run_op(DIV, 64'sd7, -64'sd2, "R2 div +/-", 0);
        run_op(REM, 64'sd7, -64'sd2, "R2 rem +/-", 0);
        run_op(DIV, -64'sd7, -64'sd2, "R2 div -/-", 0);
        run_op(REM, -64'sd7, -64'sd2, "R2 rem -/-", 0);
        run_op(DIV, 64'sd1000, 64'sd10, "R2 div +/+", 0);
    endtask

    task automatic t_div_zero;
        run_op(DIV, 64'd42, 64'd0, "R3 div by zero", 0);
        run_op(DIVU, 64'd42, 64'd0, "R3 divu by zero", 0);
        run_op(DIVW, 64'h1, 64'hFFFF_0000_0000_0000, "R3 divw by zero", 0);
        run_op(DIVUW, 64'h1, 64'h1_0000_0000, "R3 divuw by zero", 0);
    endtask

    task automatic t_rem_zero;
        run_op(REM, -64'sd42, 64'd0, "R4 rem by zero", 0);
        run_op(REMU, 64'hDEAD_BEEF_0000_0001, 64'd0, "R4 remu by zero", 0);
        run_op(REMW, 64'h1234_5678_8000_0001, 64'h5_0000_0000, "R4 remw by zero", 0);
        run_op(REMUW, 64'h0_F000_0000, 64'd0, "R4 remuw by zero", 0);
    endtask

    task automatic t_overflow;
        run_op(DIV, 64'h8000_0000_0000_0000, '1, "R5 div overflow", 0);
        run_op(REM, 64'h8000_0000_0000_0000, '1, "R5 rem overflow", 0);
        run_op(DIVW, 64'h0000_0001_8000_0000, 64'h0000_0002_FFFF_FFFF, "R5 divw overflow", 0);
        run_op(REMW, 64'h8000_0000, 64'hFFFF_FFFF, "R5 remw overflow", 0);
        run_op(DIVU, 64'h8000_0000_0000_0000, '1, "R5 divu no overflow", 0);
    endtask

    task automatic t_word;
        run_op(DIVW, 64'h1234_5678_FFFF_FFF9, 64'hABCD_0000_0000_0002, "R6 divw", 0);
        run_op(REMW, 64'h1234_5678_FFFF_FFF9, 64'hABCD_0000_0000_0002, "R6 remw", 0);
        run_op(DIVW, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6 divw neg div", 0);
        run_op(DIVUW, 64'hFFFF_FFFF_FFFF_FFFE, 64'h7777_0000_0000_0001, "R7 divuw sext", 0);
        run_op(REMUW, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0010, "R7 remuw", 0);
        run_op(DIVUW, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R7 divuw top", 0);
    endtask

    task automatic t_busy_ignore;
        bit extra;
        run_op(DIV, -64'sd1000, 64'sd7, "R11 busy ignore", 1);
        extra = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (out_done) extra = 1;
        end
        check(!extra, "R11 no extra done", 64'(extra), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unsigned();
        t_signed();
        t_div_zero();
        t_rem_zero();
        t_overflow();
        t_word();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule